// File: doc/BRIEF.md
# Reset Cause Recorder with Software One-Shot Resets

This block keeps a record of which event caused the most recent reset, and it lets software request a timed reset of the whole chip or of the processor core alone. Six hardware event pulses set sticky cause flags: power-on, the external reset pin, the watchdog, the low-voltage monitor, the brownout monitor and the processor's own reset request. The flags stay set until software clears them by writing 1 to the bit. They are held in an always-on reset domain (`keep_rst_n`), so a flag survives the reset it records.

A small register holds two self-clearing trigger bits. Bit 0 starts a whole-chip reset pulse and bit 1 starts a core-and-flash-controller reset pulse. A trigger bit is accepted only while the external protection lock is open (`prot_open` high). Once accepted, the bit stays high for `PULSE_CYC` cycles and then clears itself. The chip trigger marks the power-on cause flag and the core trigger marks the core cause flag. A third register holds level reset bits for individual peripherals. Each implemented bit drives its reset line directly.

The register port is a plain single-cycle write strobe with a combinational read mux, addressed by a 2-bit select. The block moves no data stream, so no valid/ready handshake is present.

Top module: `reset_cause_unit`

## Requirements
- R1: A one-cycle high on an event input sets its cause flag at that clock edge: `ev_por` bit 0, `ev_pin` bit 1, `ev_wdt` bit 2, `ev_lvr` bit 3, `ev_bod` bit 4, `ev_sysreq` bit 5. Bit 7 is the core one-shot flag. Bit 6 and bits 31..8 always read 0.
- R2: A cause flag is cleared only by a write to select 0 with a 1 in that bit position. Writing 0 to a flag, or writing to any other select, leaves every flag unchanged.
- R3: If a set event and a write-1-clear reach the same flag in the same cycle, the flag ends up set.
- R4: The cause flags are cleared only by `keep_rst_n`. Asserting `rst_n` clears the trigger register and the peripheral register but leaves the flags unchanged.
- R5: With `prot_open` high, a write to select 1 with bit 0 set drives `chip_rst_o` high for exactly `PULSE_CYC` (default 2) cycles, starting with the cycle after the write. Bit 0 of select 1 reads 1 during that time, and cause flag 0 is set.
- R6: With `prot_open` high, a write to select 1 with bit 1 set drives `core_rst_o` high for exactly `PULSE_CYC` cycles and sets cause flag 7. It does not drive `chip_rst_o`.
- R7: While `prot_open` is low, writes to select 1 have no effect on either reset output or on any cause flag.
- R8: Select 2 is a read/write register of level reset bits driven onto `periph_rst_o`. Only bits 1–5, 9, 12, 13, 16, 17, 20, 23 and 27 are implemented (mask 0x0893_323E). All other bits read 0 and drive 0. The register resets to 0.
- R9: Select encoding: 0 cause flags, 1 one-shot triggers (bit 0 chip, bit 1 core), 2 peripheral resets. Select 3 reads 0, and writes to select 3 change nothing.
- R10: Writing a trigger bit again while its pulse is running does not lengthen the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| keep_rst_n | input | 1 | Always-on domain reset, active low; clears cause flags |
| rst_n | input | 1 | System reset, active low; clears triggers and peripheral bits |
| ev_por | input | 1 | Power-on reset event pulse |
| ev_pin | input | 1 | External reset pin event pulse |
| ev_wdt | input | 1 | Watchdog reset event pulse |
| ev_lvr | input | 1 | Low-voltage reset event pulse |
| ev_bod | input | 1 | Brownout reset event pulse |
| ev_sysreq | input | 1 | Processor reset request event pulse |
| prot_open | input | 1 | Protection lock open; gates trigger writes |
| bus_sel | input | 2 | Register select |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_sel`, combinational |
| chip_rst_o | output | 1 | Whole-chip reset pulse |
| core_rst_o | output | 1 | Core and flash controller reset pulse |
| periph_rst_o | output | 32 | Per-peripheral reset levels |

## Verification
The bench sweeps all 256 clear masks over a full set of flags. A design that cleared on a 0 write, or that ignored the implemented-bit mask, would leave the wrong residue in the flags. It makes an event coincide with a clear of the same flag; a design that let the clear win would lose the cause. It counts the cycles of each trigger pulse, including a rewrite in the middle of a pulse. A pulse that is off by one, or that restarts on the second write, gives the wrong count. It also pulses `rst_n` with flags set, writes triggers while the lock is closed, and walks a one through all 32 peripheral bits. These tests catch flags tied to the wrong reset, a lock that leaks, and bits that should not exist.

// File: rtl/rcu_pkg.sv
package rcu_pkg;
  localparam int unsigned DATA_W = 32;

  typedef enum logic [1:0] {
    SEL_CAUSE  = 2'd0,
    SEL_SHOT   = 2'd1,
    SEL_PERIPH = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  // cause flag positions
  localparam int unsigned CF_POR  = 0;
  localparam int unsigned CF_PIN  = 1;
  localparam int unsigned CF_WDT  = 2;
  localparam int unsigned CF_LVR  = 3;
  localparam int unsigned CF_BOD  = 4;
  localparam int unsigned CF_SREQ = 5;
  localparam int unsigned CF_CORE = 7;

  localparam logic [DATA_W-1:0] CAUSE_IMPL      = 32'h0000_00BF;
  localparam logic [DATA_W-1:0] PERIPH_MASK_DEF = 32'h0893_323E;
  localparam int unsigned       PULSE_CYC_DEF   = 2;
  localparam int unsigned       NUM_SHOT        = 2;
endpackage

// File: rtl/rcu_cause_flags.sv
module rcu_cause_flags #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         keep_rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flags_o
);
  logic unused_bits;
  assign unused_bits = ^((set_i | clr_i) & ~IMPL);

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (IMPL[i]) begin : g_flag
      logic bit_q;
      always_ff @(posedge clk or negedge keep_rst_n) begin
        if (!keep_rst_n)   bit_q <= 1'b0;
        else if (set_i[i]) bit_q <= 1'b1;   // set has priority over clear
        else if (clr_i[i]) bit_q <= 1'b0;
      end
      assign flags_o[i] = bit_q;
    end else begin : g_tie
      assign flags_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/rcu_oneshot.sv
module rcu_oneshot #(
  parameter int unsigned PULSE_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic fire_o,
  output logic active_o
);
  localparam int unsigned CNT_W = $clog2(PULSE_CYC + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_CYC);

  logic [CNT_W-1:0] cnt_q;

  assign active_o = (cnt_q != '0);
  assign fire_o   = req_i && !active_o;   // no retrigger while running

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (fire_o)   cnt_q <= LOAD;
    else if (active_o) cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/rcu_periph_reg.sv
module rcu_periph_reg #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  logic unused_bits;
  assign unused_bits = ^(wdata_i & ~MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_o <= '0;
    else if (we_i) q_o <= wdata_i & MASK;
  end
endmodule

// File: rtl/reset_cause_unit.sv
module reset_cause_unit
  import rcu_pkg::*;
#(
  parameter int unsigned       PULSE_CYC   = PULSE_CYC_DEF,
  parameter logic [DATA_W-1:0] PERIPH_MASK = PERIPH_MASK_DEF
) (
  input  logic              clk,
  input  logic              keep_rst_n,
  input  logic              rst_n,
  input  logic              ev_por,
  input  logic              ev_pin,
  input  logic              ev_wdt,
  input  logic              ev_lvr,
  input  logic              ev_bod,
  input  logic              ev_sysreq,
  input  logic              prot_open,
  input  logic [1:0]        bus_sel,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              chip_rst_o,
  output logic              core_rst_o,
  output logic [DATA_W-1:0] periph_rst_o
);
  logic we_cause, we_shot, we_periph;
  assign we_cause  = bus_we && (bus_sel == SEL_CAUSE);
  assign we_shot   = bus_we && (bus_sel == SEL_SHOT);
  assign we_periph = bus_we && (bus_sel == SEL_PERIPH);

  // one-shot triggers: index 0 chip, index 1 core
  logic [NUM_SHOT-1:0] shot_fire, shot_active;
  for (genvar k = 0; k < NUM_SHOT; k++) begin : g_shot
    rcu_oneshot #(.PULSE_CYC(PULSE_CYC)) i_shot (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_i    (we_shot && prot_open && bus_wdata[k]),
      .fire_o   (shot_fire[k]),
      .active_o (shot_active[k])
    );
  end
  assign chip_rst_o = shot_active[0];
  assign core_rst_o = shot_active[1];

  // cause flags in the always-on domain
  logic [DATA_W-1:0] cause_set, cause_clr, cause_q;
  always_comb begin
    cause_set          = '0;
    cause_set[CF_POR]  = ev_por | shot_fire[0];
    cause_set[CF_PIN]  = ev_pin;
    cause_set[CF_WDT]  = ev_wdt;
    cause_set[CF_LVR]  = ev_lvr;
    cause_set[CF_BOD]  = ev_bod;
    cause_set[CF_SREQ] = ev_sysreq;
    cause_set[CF_CORE] = shot_fire[1];
  end
  assign cause_clr = we_cause ? bus_wdata : '0;

  rcu_cause_flags #(.W(DATA_W), .IMPL(CAUSE_IMPL)) i_flags (
    .clk        (clk),
    .keep_rst_n (keep_rst_n),
    .set_i      (cause_set),
    .clr_i      (cause_clr),
    .flags_o    (cause_q)
  );

  rcu_periph_reg #(.W(DATA_W), .MASK(PERIPH_MASK)) i_periph (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (we_periph),
    .wdata_i (bus_wdata),
    .q_o     (periph_rst_o)
  );

  always_comb begin
    unique case (reg_sel_e'(bus_sel))
      SEL_CAUSE:  bus_rdata = cause_q;
      SEL_SHOT:   bus_rdata = {{(DATA_W-NUM_SHOT){1'b0}}, shot_active};
      SEL_PERIPH: bus_rdata = periph_rst_o;
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/reset_cause_unit_chk.sv
module reset_cause_unit_chk
  import rcu_pkg::*;
#(
  parameter int unsigned       PULSE_CYC   = PULSE_CYC_DEF,
  parameter logic [DATA_W-1:0] PERIPH_MASK = PERIPH_MASK_DEF
) (
  input logic              clk,
  input logic              keep_rst_n,
  input logic              rst_n,
  input logic              ev_pin,
  input logic              ev_wdt,
  input logic              prot_open,
  input logic [1:0]        bus_sel,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              chip_rst_o,
  input logic              core_rst_o,
  input logic [DATA_W-1:0] periph_rst_o,
  input logic [DATA_W-1:0] cause_q
);
  logic [DATA_W-1:0] clr_now, hold_q;
  logic [7:0]        chip_hi;

  assign clr_now = (bus_we && bus_sel == SEL_CAUSE) ? bus_wdata : '0;

  always_ff @(posedge clk or negedge keep_rst_n) begin
    if (!keep_rst_n) hold_q <= '0;
    else             hold_q <= cause_q & ~clr_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          chip_hi <= '0;
    else if (chip_rst_o) chip_hi <= chip_hi + 8'd1;
    else                 chip_hi <= '0;
  end

  p_evt_pin_r1: assert property (@(posedge clk) disable iff (!keep_rst_n)
    ev_pin |=> cause_q[CF_PIN]);
  p_evt_wdt_r1: assert property (@(posedge clk) disable iff (!keep_rst_n)
    ev_wdt |=> cause_q[CF_WDT]);
  p_sticky_r2: assert property (@(posedge clk) disable iff (!keep_rst_n)
    (cause_q & hold_q) == hold_q);
  p_set_wins_r3: assert property (@(posedge clk) disable iff (!keep_rst_n)
    (ev_wdt && bus_we && bus_sel == SEL_CAUSE && bus_wdata[CF_WDT]) |=> cause_q[CF_WDT]);
  p_chip_flag_r5: assert property (@(posedge clk) disable iff (!keep_rst_n || !rst_n)
    $rose(chip_rst_o) |-> cause_q[CF_POR]);
  p_pulse_len_r5: assert property (@(posedge clk) disable iff (!keep_rst_n || !rst_n)
    $fell(chip_rst_o) |-> (chip_hi == 8'(PULSE_CYC)));
  p_core_flag_r6: assert property (@(posedge clk) disable iff (!keep_rst_n || !rst_n)
    $rose(core_rst_o) |-> cause_q[CF_CORE]);
  p_locked_r7: assert property (@(posedge clk) disable iff (!keep_rst_n || !rst_n)
    (!prot_open && bus_we && bus_sel == SEL_SHOT && !chip_rst_o) |=> !chip_rst_o);
  p_periph_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_sel == SEL_PERIPH) |=> periph_rst_o == ($past(bus_wdata) & PERIPH_MASK));
  p_no_stretch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    chip_hi <= 8'(PULSE_CYC));
endmodule

bind reset_cause_unit reset_cause_unit_chk #(.PULSE_CYC(PULSE_CYC), .PERIPH_MASK(PERIPH_MASK)) i_chk (
  .clk(clk), .keep_rst_n(keep_rst_n), .rst_n(rst_n), .ev_pin(ev_pin), .ev_wdt(ev_wdt),
  .prot_open(prot_open), .bus_sel(bus_sel), .bus_we(bus_we), .bus_wdata(bus_wdata),
  .chip_rst_o(chip_rst_o), .core_rst_o(core_rst_o), .periph_rst_o(periph_rst_o),
  .cause_q(cause_q)
);

// File: tb/test_reset_cause_unit.sv
module test_reset_cause_unit;
  localparam logic [31:0] PMASK  = 32'h0893_323E;
  localparam logic [31:0] CIMPL  = 32'h0000_00BF;
  localparam int          PULSE  = 2;

  logic clk = 1'b0, keep_rst_n = 1'b0, rst_n = 1'b0;
  logic ev_por = 0, ev_pin = 0, ev_wdt = 0, ev_lvr = 0, ev_bod = 0, ev_sysreq = 0;
  logic prot_open = 0, bus_we = 0;
  logic [1:0]  bus_sel = 0;
  logic [31:0] bus_wdata = 0, bus_rdata, periph_rst_o;
  logic chip_rst_o, core_rst_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  reset_cause_unit i_reset_cause_unit (
    .clk(clk), .keep_rst_n(keep_rst_n), .rst_n(rst_n),
    .ev_por(ev_por), .ev_pin(ev_pin), .ev_wdt(ev_wdt), .ev_lvr(ev_lvr),
    .ev_bod(ev_bod), .ev_sysreq(ev_sysreq), .prot_open(prot_open),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .chip_rst_o(chip_rst_o), .core_rst_o(core_rst_o), .periph_rst_o(periph_rst_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk); bus_sel = sel; bus_wdata = d; bus_we = 1;
    @(negedge clk); bus_we = 0; bus_wdata = 0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] d);
    @(negedge clk); bus_sel = sel; #1 d = bus_rdata;
  endtask

  task automatic events(input logic [5:0] v);
    @(negedge clk);
    {ev_sysreq, ev_bod, ev_lvr, ev_wdt, ev_pin, ev_por} = v;
    @(negedge clk);
    {ev_sysreq, ev_bod, ev_lvr, ev_wdt, ev_pin, ev_por} = '0;
  endtask

  // write trigger at sel 1, optionally rewrite next cycle, count high cycles
  task automatic shot(input logic [31:0] d, input bit rewrite, output int chip_n,
                      output int core_n, output logic [31:0] rb);
    chip_n = 0; core_n = 0; rb = 0;
    @(negedge clk); bus_sel = 2'd1; bus_wdata = d; bus_we = 1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (!(rewrite && k == 0)) begin bus_we = 0; bus_wdata = 0; end
      #1;
      if (k == 0) rb = bus_rdata;
      if (chip_rst_o) chip_n++;
      if (core_rst_o) core_n++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int cn, kn;
    repeat (3) @(negedge clk);
    keep_rst_n = 1; rst_n = 1;

    // reset state (R4, R8, R9)
    rd(2'd0, d); check("R4 flags after reset", d, 0);
    rd(2'd1, d); check("R9 triggers after reset", d, 0);
    rd(2'd2, d); check("R8 periph after reset", d, 0);
    check("R5 chip output idle", {31'b0, chip_rst_o}, 0);
    check("R6 core output idle", {31'b0, core_rst_o}, 0);

    // R1: each event alone
    for (int b = 0; b < 6; b++) begin
      wr(2'd0, 32'hFFFF_FFFF);
      events(6'(1 << b));
      rd(2'd0, d); check("R1 single event flag", d, 32'(1) << b);
    end
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d); check("R2 clear all", d, 0);

    // R2: exhaustive clear masks
    for (int m = 0; m < 256; m++) begin
      events(6'h3F);
      wr(2'd1, 32'h0);              // locked write elsewhere: no effect on flags
      wr(2'd0, 32'(m));
      rd(2'd0, d); check("R2 clear mask sweep", d, 32'h3F & ~32'(m));
      wr(2'd0, 32'hFF);
    end

    // R9: select 3
    events(6'h3F);
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd0, d); check("R9 write to sel 3 ignored (flags)", d, 32'h3F);
    rd(2'd2, d); check("R9 write to sel 3 ignored (periph)", d, 0);
    rd(2'd3, d); check("R9 sel 3 reads zero", d, 0);
    wr(2'd0, 32'hFF);

    // R3: set wins over same-cycle clear
    @(negedge clk); ev_wdt = 1; bus_sel = 2'd0; bus_wdata = 32'hFF; bus_we = 1;
    @(negedge clk); ev_wdt = 0; bus_we = 0; bus_wdata = 0;
    rd(2'd0, d); check("R3 set beats clear", d, 32'h04);

    // R4: system reset keeps flags, clears periph
    wr(2'd2, 32'hFFFF_FFFF);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    rd(2'd0, d); check("R4 flags survive rst_n", d, 32'h04);
    rd(2'd2, d); check("R4 periph cleared by rst_n", d, 0);
    wr(2'd0, 32'hFF);

    // R7: locked
    prot_open = 0;
    shot(32'h3, 0, cn, kn, d);
    check("R7 locked chip pulse", 32'(cn), 0);
    check("R7 locked core pulse", 32'(kn), 0);
    rd(2'd0, d); check("R7 locked no flags", d, 0);

    // R5: chip one-shot
    prot_open = 1;
    shot(32'h1, 0, cn, kn, d);
    check("R5 chip pulse length", 32'(cn), PULSE);
    check("R5 chip readback", d, 32'h1);
    check("R6 core idle during chip", 32'(kn), 0);
    rd(2'd0, d); check("R5 chip sets flag 0", d, 32'h01);
    rd(2'd1, d); check("R5 trigger self-cleared", d, 0);
    wr(2'd0, 32'hFF);

    // R6: core one-shot
    shot(32'h2, 0, cn, kn, d);
    check("R6 core pulse length", 32'(kn), PULSE);
    check("R6 no chip pulse", 32'(cn), 0);
    check("R6 core readback", d, 32'h2);
    rd(2'd0, d); check("R6 core sets flag 7", d, 32'h80);
    wr(2'd0, 32'hFF);

    // R10: rewrite during pulse
    shot(32'h1, 1, cn, kn, d);
    check("R10 no stretch", 32'(cn), PULSE);
    wr(2'd0, 32'hFF);
    prot_open = 0;

    // R8: walking one over peripheral register
    for (int i = 0; i < 32; i++) begin
      wr(2'd2, 32'(1) << i);
      rd(2'd2, d); check("R8 periph readback", d, (32'(1) << i) & PMASK);
      check("R8 periph output", periph_rst_o, (32'(1) << i) & PMASK);
    end
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, d); check("R8 periph all ones", d, PMASK);
    rd(2'd0, d); check("R2 other writes keep flags", d, 0 & CIMPL);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule